// File: doc/BRIEF.md
# DDR3 Training Command Sequencer

This block drives the raw DDR3 command pins of one memory channel while the memory is being trained. Software fills up to four command slots through a simple register write port. For each slot it sets the levels of the three active-low command strobes, the row/column address, the bank, the rank to select and how long to stay quiet after the command. A write to the start register then gives the number of slots to run. The block plays them back as a batch.

Each slot's command appears on the pins for a single cycle with the chosen rank selected. A run of NOP cycles follows, as long as that slot's idle count, before the next slot is played. After the last slot's idle time has run out, busy drops and done pulses once. Software polls this before it loads the next batch. While a batch runs, the slot contents and the start register are locked against writes.

Top module: `cmdq_sequencer`

## Requirements
- R1: After reset, ddr_ras_n, ddr_cas_n and ddr_we_n are high, every ddr_cs_n bit is high, ddr_row and ddr_bank are zero, and busy and done are low.
- R2: wr_addr[3:2] picks the register kind (0 command, 1 location, 2 idle, 3 start) and wr_addr[1:0] picks the slot. In a command word, bit 0 is the RAS level, bit 1 the CAS level and bit 2 the WE level, where 1 means high. In a location word, bits 15:0 are the row/column address, bits 22:20 the bank and bits 25:24 the rank. In an idle word, bits 31:16 are the idle count.
- R3: During a slot's issue cycle, the strobes carry that slot's levels, ddr_row and ddr_bank carry its fields, and only ddr_cs_n[rank] is low. This lasts exactly one cycle. In every other cycle all three strobes are high, all ddr_cs_n bits are high, and ddr_row and ddr_bank are zero.
- R4: A start write (kind 3) with bit 0 set runs a batch. Bits 20:16 hold (slot count - 1) * 4, so bits 19:18 give count - 1, and bits 20, 17 and 16 are ignored. A start write with bit 0 clear has no effect.
- R5: The first command appears in the cycle right after the start write is sampled. Slots run in ascending order starting from slot 0.
- R6: After a slot with idle count N issues, exactly N NOP cycles pass before the next slot issues. With N = 0, the next slot issues in the following cycle.
- R7: busy is high from the first issue cycle until the last slot's idle cycles have elapsed. Writes to slot registers while busy is high leave the slots unchanged.
- R8: A start write while busy is high neither restarts nor extends the running batch.
- R9: done is high for exactly one cycle: the first cycle after the batch in which busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register kind [3:2] and slot [1:0] |
| wr_data | input | 32 | Register write data |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_cs_n | output | 4 | Per-rank chip selects, active low |
| ddr_row | output | 16 | Row/column address |
| ddr_bank | output | 3 | Bank address |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle batch-complete pulse |

## Verification
The hardest case to reach is a write that lands while the engine is part-way through an idle wait. A stray slot write or a second start there would change a command that has not yet been played. The stimulus gives slot 0 a long idle count and starts a two-slot batch. During that wait it rewrites slot 1's address, reissues start and clears slot 0's idle count. It then checks that slot 1 still comes out with its old address, at the time the original counts predict, and that exactly two commands appear. A cycle-by-cycle model of the pins, busy and done runs alongside every test.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int WORD_W   = 32;
    localparam int ROW_W    = 16;
    localparam int BANK_W   = 3;
    localparam int RSEL_W   = 2;
    localparam int WAIT_W   = 16;
    localparam int RANKS    = 1 << RSEL_W;
    localparam int ROW_LSB  = 0;
    localparam int BANK_LSB = 20;
    localparam int RSEL_LSB = 24;
    localparam int WAIT_LSB = 16;
    localparam int GO_BIT   = 0;
    localparam int CNT_LSB  = 18;

    localparam logic [2:0] PINS_NOP = 3'b111;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_LOC  = 2'd1,
        REG_WAIT = 2'd2,
        REG_GO   = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [2:0]        pins;   // {we, cas, ras} levels
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [RSEL_W-1:0] rsel;
        logic [WAIT_W-1:0] hold;
    } slot_t;
endpackage

// File: rtl/cmdq_slot_bank.sv
module cmdq_slot_bank
    import cmdq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [IDX_W-1:0]        wr_slot,
    input  logic [WORD_W-1:0]       wr_data,
    output slot_t [SLOTS-1:0]       slots_o
);
    localparam slot_t SLOT_RST = '{pins: PINS_NOP, row: '0, bank: '0, rsel: '0, hold: '0};

    slot_t [SLOTS-1:0] slot_d, slot_q;
    logic  [SLOTS-1:0] hit;

    // Per-slot write decode; locked while a batch runs
    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit[g] = wr_en && !busy && (wr_slot == IDX_W'(g));
    end

    always_comb begin
        slot_d = slot_q;
        for (int s = 0; s < SLOTS; s++) begin
            if (hit[s]) begin
                case (wr_kind)
                    REG_CMD:  slot_d[s].pins = wr_data[2:0];
                    REG_LOC: begin
                        slot_d[s].row  = wr_data[ROW_LSB  +: ROW_W];
                        slot_d[s].bank = wr_data[BANK_LSB +: BANK_W];
                        slot_d[s].rsel = wr_data[RSEL_LSB +: RSEL_W];
                    end
                    REG_WAIT: slot_d[s].hold = wr_data[WAIT_LSB +: WAIT_W];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= {SLOTS{SLOT_RST}};
        else        slot_q <= slot_d;
    end

    assign slots_o = slot_q;

    // R7: slot contents frozen across any write issued while busy
    assert_slots_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(slot_q));
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [IDX_W-1:0]  go_last,
    input  logic [WAIT_W-1:0] cur_hold,
    output logic [IDX_W-1:0]  idx_o,
    output logic              fire_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SLOTS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [WAIT_W-1:0] cnt;
        logic              done;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_IDLE, idx: '0, last: '0, cnt: '0, done: 1'b0};

    eng_t e_d, e_q;
    logic step;

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        step     = 1'b0;
        case (e_q.st)
            ST_IDLE: begin
                if (go) begin
                    e_d.st   = ST_FIRE;
                    e_d.idx  = '0;
                    e_d.last = (go_last > TOP_IDX) ? TOP_IDX : go_last;
                    e_d.cnt  = '0;
                end
            end
            ST_FIRE: begin
                if (cur_hold == '0) begin
                    step = 1'b1;
                end else begin
                    e_d.st  = ST_HOLD;
                    e_d.cnt = cur_hold;
                end
            end
            ST_HOLD: begin
                if (e_q.cnt <= WAIT_W'(1)) step = 1'b1;
                else                       e_d.cnt = e_q.cnt - WAIT_W'(1);
            end
            default: e_d.st = ST_IDLE;
        endcase
        if (step) begin
            if (e_q.idx == e_q.last) begin
                e_d.st   = ST_IDLE;
                e_d.done = 1'b1;
            end else begin
                e_d.idx = e_q.idx + IDX_W'(1);
                e_d.st  = ST_FIRE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= ENG_RST;
        else        e_q <= e_d;
    end

    assign idx_o  = e_q.idx;
    assign fire_o = (e_q.st == ST_FIRE);
    assign busy_o = (e_q.st != ST_IDLE);
    assign done_o = e_q.done;

    // R5: an accepted start plays slot 0 in the next cycle
    assert_start_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy_o) |=> (fire_o && idx_o == '0));
    // R8: a start during a batch past slot 0 never rewinds it
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && busy_o && idx_o != '0) |=> (idx_o != '0 || !busy_o));
    // R3: a slot is fired for one cycle only
    assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !(fire_o && idx_o == $past(idx_o)));
    // R6: the wait continues while count remains
    assert_hold_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_HOLD && e_q.cnt > WAIT_W'(1)) |=> (e_q.st == ST_HOLD));
    // R9: done is a single pulse right after busy falls
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/cmdq_pin_drive.sv
module cmdq_pin_drive
    import cmdq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  slot_t             cur,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [RANKS-1:0]  cs_n,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank
);
    always_comb begin
        {we_n, cas_n, ras_n} = PINS_NOP;
        cs_n = '1;
        row  = '0;
        bank = '0;
        if (fire) begin
            {we_n, cas_n, ras_n} = cur.pins;
            cs_n[cur.rsel]       = 1'b0;
            row                  = cur.row;
            bank                 = cur.bank;
        end
    end

    // R3: never more than one rank selected
    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R3: outside an issue cycle the bus is a deselected NOP
    assert_quiet_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |-> ((&cs_n) && ras_n && cas_n && we_n && row == '0 && bank == '0));
endmodule

// File: rtl/cmdq_sequencer.sv
module cmdq_sequencer
    import cmdq_pkg::*;
#(
    parameter  int SLOTS  = 4,
    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [RANKS-1:0]  ddr_cs_n,
    output logic [ROW_W-1:0]  ddr_row,
    output logic [BANK_W-1:0] ddr_bank,
    output logic              busy,
    output logic              done
);
    logic [1:0]        wr_kind;
    logic [IDX_W-1:0]  wr_slot;
    logic              go;
    logic [IDX_W-1:0]  go_last;
    slot_t [SLOTS-1:0] slots;
    slot_t             cur;
    logic [IDX_W-1:0]  idx;
    logic              fire;

    assign wr_kind = wr_addr[IDX_W +: 2];
    assign wr_slot = wr_addr[IDX_W-1:0];
    assign go      = wr_en && (wr_kind == REG_GO) && wr_data[GO_BIT];
    assign go_last = wr_data[CNT_LSB +: IDX_W];
    assign cur     = slots[idx];

    cmdq_slot_bank #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .slots_o (slots)
    );

    cmdq_engine #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_last  (go_last),
        .cur_hold (cur.hold),
        .idx_o    (idx),
        .fire_o   (fire),
        .busy_o   (busy),
        .done_o   (done)
    );

    cmdq_pin_drive u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .cur   (cur),
        .ras_n (ddr_ras_n),
        .cas_n (ddr_cas_n),
        .we_n  (ddr_we_n),
        .cs_n  (ddr_cs_n),
        .row   (ddr_row),
        .bank  (ddr_bank)
    );
endmodule

// File: tb/tb_cmdq_sequencer.sv
`timescale 1ns/1ps
module tb_cmdq_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ddr_ras_n, ddr_cas_n, ddr_we_n, busy, done;
    logic [3:0]  ddr_cs_n;
    logic [15:0] ddr_row;
    logic [2:0]  ddr_bank;

    always #2 clk = ~clk;

    cmdq_sequencer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
        .ddr_cs_n(ddr_cs_n), .ddr_row(ddr_row), .ddr_bank(ddr_bank),
        .busy(busy), .done(done)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit started = 0;

    typedef struct packed {
        logic [2:0]  pins;  // {we, cas, ras}
        logic [3:0]  cs_n;
        logic [15:0] row;
        logic [2:0]  bank;
        logic        busy;
        logic        done;
    } exp_t;

    // Behavioural model state
    exp_t        cur_e;
    exp_t        q[$];
    logic [2:0]  m_pins [4];
    logic [15:0] m_row  [4];
    logic [2:0]  m_bank [4];
    logic [1:0]  m_rsel [4];
    int          m_hold [4];

    // Port logs
    int          iss_cyc[$];
    logic [15:0] iss_row[$];
    logic [3:0]  iss_cs[$];
    logic [2:0]  iss_pins[$];
    logic [2:0]  iss_bank[$];
    int          done_log[$];

    function automatic exp_t quiet(input logic b, input logic d);
        exp_t e;
        e.pins = 3'b111; e.cs_n = 4'hF; e.row = '0; e.bank = '0; e.busy = b; e.done = d;
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model, advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            cur_e = quiet(1'b0, 1'b0);
            for (int i = 0; i < 4; i++) begin
                m_pins[i] = 3'b111; m_row[i] = '0; m_bank[i] = '0; m_rsel[i] = '0; m_hold[i] = 0;
            end
        end else begin
            if (wr_en && !cur_e.busy) begin
                case (wr_addr[3:2])
                    2'd0: m_pins[wr_addr[1:0]] = wr_data[2:0];
                    2'd1: begin
                        m_row[wr_addr[1:0]]  = wr_data[15:0];
                        m_bank[wr_addr[1:0]] = wr_data[22:20];
                        m_rsel[wr_addr[1:0]] = wr_data[25:24];
                    end
                    2'd2: m_hold[wr_addr[1:0]] = int'(wr_data[31:16]);
                    default: begin
                        if (wr_data[0]) begin
                            for (int s = 0; s <= int'(wr_data[19:18]); s++) begin
                                exp_t e;
                                e.pins = m_pins[s]; e.cs_n = ~(4'b1 << m_rsel[s]);
                                e.row = m_row[s]; e.bank = m_bank[s]; e.busy = 1'b1; e.done = 1'b0;
                                q.push_back(e);
                                for (int h = 0; h < m_hold[s]; h++) q.push_back(quiet(1'b1, 1'b0));
                            end
                            q.push_back(quiet(1'b0, 1'b1));
                        end
                    end
                endcase
            end
            if (q.size() > 0) cur_e = q.pop_front();
            else              cur_e = quiet(1'b0, 1'b0);
        end
        started = 1'b1;
    end

    // Per-cycle comparison and port logging, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk({ddr_we_n, ddr_cas_n, ddr_ras_n, ddr_cs_n, ddr_row, ddr_bank} ==
                {cur_e.pins, cur_e.cs_n, cur_e.row, cur_e.bank}, "R3 pins",
                64'({ddr_we_n, ddr_cas_n, ddr_ras_n, ddr_cs_n, ddr_row, ddr_bank}),
                64'({cur_e.pins, cur_e.cs_n, cur_e.row, cur_e.bank}));
            chk(busy == cur_e.busy, "R7 busy", 64'(busy), 64'(cur_e.busy));
            chk(done == cur_e.done, "R9 done", 64'(done), 64'(cur_e.done));
        end
        if (rst_n && ddr_cs_n != 4'hF) begin
            iss_cyc.push_back(cyc); iss_row.push_back(ddr_row); iss_cs.push_back(ddr_cs_n);
            iss_pins.push_back({ddr_we_n, ddr_cas_n, ddr_ras_n}); iss_bank.push_back(ddr_bank);
        end
        if (rst_n && done) done_log.push_back(cyc);
    end

    task automatic wr(input logic [1:0] kind, input logic [1:0] slot, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {kind, slot}; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    function automatic logic [31:0] loc_word(input logic [15:0] r, input logic [2:0] b, input logic [1:0] k);
        return {6'b0, k, 1'b0, b, 4'b0, r};
    endfunction

    function automatic logic [31:0] go_word(input int n);
        return 32'h1 | (32'((n - 1) * 4) << 16);
    endfunction

    task automatic clear_logs();
        iss_cyc.delete(); iss_row.delete(); iss_cs.delete(); iss_pins.delete(); iss_bank.delete();
        done_log.delete();
    endtask

    task automatic load_slot(input int s, input logic [2:0] p, input logic [15:0] r,
                             input logic [2:0] b, input logic [1:0] k, input int h);
        wr(2'd0, 2'(s), {29'b0, p});
        wr(2'd1, 2'(s), loc_word(r, b, k));
        wr(2'd2, 2'(s), {16'(h), 16'b0});
    endtask

    // Checks issue count, timing, order and done position of a batch
    task automatic finish_batch(input int n, input int k0, input int hs[4], input logic [15:0] rows[4], input string tag);
        int t;
        for (int w = 0; w < 400 && done_log.size() == 0; w++) @(negedge clk);
        @(negedge clk);
        chk(iss_cyc.size() == n, {tag, " R4 issue count"}, 64'(iss_cyc.size()), 64'(n));
        t = k0;
        for (int i = 0; i < n && i < iss_cyc.size(); i++) begin
            chk(iss_cyc[i] == t, (i == 0) ? {tag, " R5 first issue cycle"} : {tag, " R6 issue spacing"},
                64'(iss_cyc[i]), 64'(t));
            chk(iss_row[i] == rows[i], {tag, " R5 slot order"}, 64'(iss_row[i]), 64'(rows[i]));
            t += 1 + hs[i];
        end
        chk(done_log.size() == 1 && done_log[0] == t, {tag, " R9 done cycle"},
            64'((done_log.size() > 0) ? done_log[0] : -1), 64'(t));
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k0;
        int hs[4];
        logic [15:0] rows[4];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk({ddr_ras_n, ddr_cas_n, ddr_we_n} == 3'b111, "R1 strobes", 64'({ddr_ras_n, ddr_cas_n, ddr_we_n}), 64'h7);
        chk(ddr_cs_n == 4'hF && ddr_row == 0 && ddr_bank == 0, "R1 selects/address",
            64'({ddr_cs_n, ddr_row, ddr_bank}), 64'({4'hF, 16'h0, 3'h0}));
        chk(!busy && !done, "R1 status", 64'({busy, done}), 64'h0);

        // Full four-slot batch with mixed idle counts
        load_slot(0, 3'b000, 16'h1234, 3'd5, 2'd2, 2);
        load_slot(1, 3'b101, 16'h00AB, 3'd1, 2'd0, 0);
        load_slot(2, 3'b010, 16'hBEEF, 3'd7, 2'd3, 3);
        load_slot(3, 3'b110, 16'h0F0F, 3'd2, 2'd1, 1);
        hs = '{2, 0, 3, 1};
        rows = '{16'h1234, 16'h00AB, 16'hBEEF, 16'h0F0F};
        clear_logs();
        wr(2'd3, 2'd0, go_word(4));
        k0 = cyc;
        finish_batch(4, k0, hs, rows, "four-slot");
        // R2: fields land on the pins at their stated positions
        if (iss_cyc.size() > 2) begin
            chk(iss_cs[0] == 4'b1011 && iss_bank[0] == 3'd5 && iss_pins[0] == 3'b000, "R2 slot0 fields",
                64'({iss_cs[0], iss_bank[0], iss_pins[0]}), 64'({4'b1011, 3'd5, 3'b000}));
            chk(iss_cs[2] == 4'b0111 && iss_bank[2] == 3'd7 && iss_pins[2] == 3'b010, "R2 slot2 fields",
                64'({iss_cs[2], iss_bank[2], iss_pins[2]}), 64'({4'b0111, 3'd7, 3'b010}));
        end

        // R4: single slot, with the ignored count bits set
        clear_logs();
        wr(2'd3, 2'd0, 32'h0013_0001);
        k0 = cyc;
        finish_batch(1, k0, hs, rows, "one-slot");

        // R4: two slots
        clear_logs();
        wr(2'd3, 2'd1, go_word(2));
        k0 = cyc;
        finish_batch(2, k0, hs, rows, "two-slot");

        // R4: start without bit 0 does nothing
        clear_logs();
        wr(2'd3, 2'd0, 32'h000C_0000);
        repeat (10) @(negedge clk);
        chk(iss_cyc.size() == 0 && done_log.size() == 0, "R4 start bit clear",
            64'(iss_cyc.size() + done_log.size()), 64'h0);

        // R7/R8: writes and a second start during an idle wait
        wr(2'd2, 2'd0, {16'd20, 16'b0});
        hs = '{20, 0, 3, 1};
        clear_logs();
        wr(2'd3, 2'd0, go_word(2));
        k0 = cyc;
        repeat (3) @(negedge clk);
        chk(busy, "R7 busy during wait", 64'(busy), 64'h1);
        wr(2'd1, 2'd1, loc_word(16'hDEAD, 3'd4, 2'd3));
        wr(2'd3, 2'd0, go_word(4));
        wr(2'd2, 2'd0, 32'h0);
        finish_batch(2, k0, hs, rows, "busy-lock R8");
        if (iss_row.size() > 1)
            chk(iss_row[1] == 16'h00AB && iss_cs[1] == 4'b1110, "R7 slot1 unchanged",
                64'({iss_row[1], iss_cs[1]}), 64'({16'h00AB, 4'b1110}));

        // R7: the slot 0 idle write made during busy was dropped as well
        clear_logs();
        wr(2'd3, 2'd0, go_word(1));
        k0 = cyc;
        finish_batch(1, k0, hs, rows, "post-lock R7");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule